// File: doc/BRIEF.md
# Gated Pulse Accumulator

This block counts activity on one external input pin into a 16-bit counter. It has two modes. In event mode each selected transition of the pin adds one to the count. In gated mode the pin acts as a gate: while it sits at its active level, every pulse of an externally supplied tick enable adds one. The tick enable normally comes from a clock divider outside this block. The pin always passes through a synchronizer before any edge is detected.

Software uses a small register set with separate write and read address ports. A control register selects the mode, the polarity and two interrupt enables. The count can be read, and it can be loaded directly. A flag register reports counter wrap and input activity. Writing a one to a flag bit clears that bit. The single interrupt output is raised whenever an enabled flag is set.

Top module: `pulse_accum`

## Requirements
- R1: After reset, every register reads 0x0000 and `irq` is low.
- R2: In event mode (control bit 0 = 0), the count increments once per selected pin edge. Control bit 1 picks the edge: 0 for rising, 1 for falling. The new value is readable within three clocks after the pin changes.
- R3: In gated mode (control bit 0 = 1), the count increments on each clock where `gate_tick` is high and the synchronized pin is at its active level. The active level is high when control bit 1 = 0 and low when control bit 1 = 1. A window that is active for N clocks with `gate_tick` held high adds exactly N.
- R4: When the count wraps from 0xFFFF to 0x0000 because of an increment, the overflow flag (flag bit 1) sets.
- R5: In event mode, the edge flag (flag bit 0) sets on every selected edge.
- R6: In gated mode, the edge flag sets when the gate window closes, and not when it opens.
- R7: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R8: Flag register bits 15..2 and control register bits 15..4 always read 0.
- R9: A write to the count loads the written value. If an increment falls in the same cycle as the write, the written value is kept and the increment is dropped.
- R10: If a hardware set and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` = (overflow flag AND control bit 2) OR (edge flag AND control bit 3).
- R12: Register map: address 0 is control, address 1 is flags, address 2 is the count, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External input pin, asynchronous |
| gate_tick | input | 1 | One-clock enable pulses that are counted in gated mode |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or skipped step in the synchronizer or the edge detector shows up as a count that is off by one after a single pulse. In gated mode the same fault shows as a window that adds N±1 instead of N. A polarity inversion shows up as the edge flag setting when the window opens, which can be seen while the pin is still active. A wrong collision priority between a write and an increment, or between a set and a clear, is visible at the very next read of the count or the flags. Faults in the interrupt path appear on `irq` in the same cycle that the control or flag register changes.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
   localparam int ADDR_W = 2;
   localparam int CTRL_W = 4;
   localparam int NFLAG  = 2;

   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_FLAGS = 2'd1;
   localparam logic [ADDR_W-1:0] A_COUNT = 2'd2;

   localparam int FL_EDGE = 0;
   localparam int FL_OVF  = 1;

   typedef struct packed {
      logic edge_ie;   // bit 3
      logic ovf_ie;    // bit 2
      logic pol;       // bit 1
      logic gated;     // bit 0
   } ctrl_t;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic level,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pacc_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~last_q;
   assign fall  = ~level & last_q;
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (inc)  cnt_q <= cnt_q + 1'b1;
   end

   assign wrap  = inc & ~load & (cnt_q == TOP);
   assign count = cnt_q;
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
   import pacc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   input  logic              gate_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("pulse_accum: CNT_W must lie in 2..DATA_W");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("pulse_accum: DATA_W too narrow for control register");
   end

   ctrl_t            ctrl_q;
   logic             pin_lvl, pin_rise, pin_fall;
   logic             gate_on, inc, edge_set, cnt_wr, cnt_wrap;
   logic [CNT_W-1:0] cnt_q;
   logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
   logic             ovf_flag, edge_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en && wr_addr == A_CTRL)
         ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .level  (pin_lvl),
      .rise   (pin_rise),
      .fall   (pin_fall)
   );

   assign gate_on = pin_lvl ^ ctrl_q.pol;

   always_comb begin
      if (ctrl_q.gated) begin
         inc      = gate_on & gate_tick;
         edge_set = ctrl_q.pol ? pin_rise : pin_fall;
      end else begin
         inc      = ctrl_q.pol ? pin_fall : pin_rise;
         edge_set = inc;
      end
   end

   assign cnt_wr = wr_en && (wr_addr == A_COUNT);

   pacc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc),
      .load     (cnt_wr),
      .load_val (wr_data[CNT_W-1:0]),
      .count    (cnt_q),
      .wrap     (cnt_wrap)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[FL_EDGE] = edge_set;
      flag_set[FL_OVF]  = cnt_wrap;
      flag_clr          = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFLAG-1:0] : '0;
   end

   pacc_flags #(.N(NFLAG)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .q     (flag_q)
   );

   assign ovf_flag  = flag_q[FL_OVF];
   assign edge_flag = flag_q[FL_EDGE];
   assign irq       = (ovf_flag & ctrl_q.ovf_ie) | (edge_flag & ctrl_q.edge_ie);

   logic [DATA_W-1:0] cnt_rd;
   if (CNT_W == DATA_W) begin : g_cnt_full
      assign cnt_rd = cnt_q;
   end else begin : g_cnt_pad
      assign cnt_rd = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
         A_FLAGS: rd_data[NFLAG-1:0]  = flag_q;
         A_COUNT: rd_data             = cnt_rd;
         default: rd_data             = '0;
      endcase
   end
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker
   import pacc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              inc,
   input logic              edge_set,
   input logic              ovf_flag,
   input logic              edge_flag
);
   logic cnt_write, edge_clr;
   assign cnt_write = wr_en && (wr_addr == A_COUNT);
   assign edge_clr  = wr_en && (wr_addr == A_FLAGS) && wr_data[FL_EDGE];

   AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !cnt_write && cnt_q == {CNT_W{1'b1}}) |=> (ovf_flag && cnt_q == '0)); // R4
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_write |=> (cnt_q == $past(wr_data[CNT_W-1:0]))); // R9
   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_write && !inc) |=> $stable(cnt_q)); // R2
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_set |=> edge_flag); // R10
   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_set && !edge_clr) |=> $stable(edge_flag)); // R7
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_flag || edge_flag)); // R11
   AST_FLAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == A_FLAGS) |-> (rd_data[DATA_W-1:NFLAG] == '0)); // R8
endmodule

bind pulse_accum pacc_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data),
   .irq       (irq),
   .cnt_q     (cnt_q),
   .inc       (inc),
   .edge_set  (edge_set),
   .ovf_flag  (ovf_flag),
   .edge_flag (edge_flag)
);

// File: tb/pulse_accum_tb_top.sv
module pulse_accum_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b0;
   logic        gate_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pulse_accum dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gate_tick(gate_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   typedef struct {
      bit          is_irq;
      logic [1:0]  addr;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t sb_q[$];

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         @(negedge clk);
         rd_addr = sb_q[0].addr;
         #1;
         n_checks++;
         if (sb_q[0].is_irq) begin
            if (irq !== sb_q[0].exp[0]) begin
               n_fail++;
               $display("FAIL %s irq actual=%0b expected=%0b", sb_q[0].tag, irq, sb_q[0].exp[0]);
            end
         end else if (rd_data !== sb_q[0].exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=0x%04h expected=0x%04h",
                     sb_q[0].tag, sb_q[0].addr, rd_data, sb_q[0].exp);
         end
         void'(sb_q.pop_front());
      end
   end

   task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string t);
      item_t it;
      it.is_irq = 0; it.addr = a; it.exp = e; it.tag = t;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic expect_irq(input bit e, input string t);
      item_t it;
      it.is_irq = 1; it.addr = 2'd0; it.exp = {15'd0, e}; it.tag = t;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pin_pulse(input bit lvl, input int len);
      @(negedge clk);
      pin_in = lvl;
      repeat (len) @(negedge clk);
      pin_in = ~lvl;
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state and map
      expect_reg(2'd0, 16'h0000, "R1 ctrl");
      expect_reg(2'd1, 16'h0000, "R1 flags");
      expect_reg(2'd2, 16'h0000, "R1 count");
      expect_reg(2'd3, 16'h0000, "R12 unmapped");
      expect_irq(1'b0, "R1 irq");

      // event mode, rising edges
      for (int i = 0; i < 3; i++) pin_pulse(1'b1, 4);
      expect_reg(2'd2, 16'd3, "R2 rising count");
      expect_reg(2'd1, 16'h0001, "R5 edge flag");
      reg_write(2'd1, 16'h0000);
      expect_reg(2'd1, 16'h0001, "R7 write zero");
      reg_write(2'd1, 16'hFFFF);
      expect_reg(2'd1, 16'h0000, "R7 write one R8");

      // falling edges; unused control bits
      reg_write(2'd0, 16'hFFF2);
      expect_reg(2'd0, 16'h0002, "R8 ctrl upper R12");
      for (int i = 0; i < 2; i++) pin_pulse(1'b1, 4);
      expect_reg(2'd2, 16'd5, "R2 falling count");
      expect_reg(2'd1, 16'h0001, "R5 falling flag");
      reg_write(2'd0, 16'h000A);
      expect_irq(1'b1, "R11 edge irq");
      reg_write(2'd0, 16'h0002);
      expect_irq(1'b0, "R11 edge masked");
      reg_write(2'd1, 16'h0003);

      // overflow
      reg_write(2'd0, 16'h0004);
      reg_write(2'd2, 16'hFFFE);
      expect_reg(2'd2, 16'hFFFE, "R9 load");
      for (int i = 0; i < 2; i++) pin_pulse(1'b1, 4);
      expect_reg(2'd2, 16'h0000, "R4 wrap count");
      expect_reg(2'd1, 16'h0003, "R4 ovf flag");
      expect_irq(1'b1, "R11 ovf irq");
      reg_write(2'd1, 16'h0002);
      expect_reg(2'd1, 16'h0001, "R7 partial clear");
      reg_write(2'd1, 16'h0003);

      // gated active high, tick every clock
      reg_write(2'd0, 16'h0001);
      reg_write(2'd2, 16'h0000);
      gate_tick = 1'b1;
      pin_pulse(1'b1, 7);
      expect_reg(2'd2, 16'd7, "R3 gated high window");
      expect_reg(2'd1, 16'h0001, "R6 trailing sets");
      reg_write(2'd1, 16'h0001);
      @(negedge clk); pin_in = 1'b1;
      repeat (5) @(negedge clk);
      expect_reg(2'd1, 16'h0000, "R6 leading no set");
      pin_in = 1'b0;
      repeat (5) @(negedge clk);
      expect_reg(2'd1, 16'h0001, "R6 close sets");

      // half-rate ticks
      reg_write(2'd2, 16'h0000);
      @(negedge clk); pin_in = 1'b1; gate_tick = 1'b0;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         gate_tick = ~gate_tick;
         if (i == 9) pin_in = 1'b0;
      end
      gate_tick = 1'b0;
      repeat (4) @(negedge clk);
      expect_reg(2'd2, 16'd5, "R3 half-rate ticks");

      // gated active low
      @(negedge clk); pin_in = 1'b1;
      repeat (5) @(negedge clk);
      reg_write(2'd0, 16'h0003);
      reg_write(2'd2, 16'h0000);
      reg_write(2'd1, 16'h0003);
      gate_tick = 1'b1;
      pin_pulse(1'b0, 6);
      expect_reg(2'd2, 16'd6, "R3 gated low window");
      expect_reg(2'd1, 16'h0001, "R6 low trailing");

      // write beats increment (gate active, pin low)
      gate_tick = 1'b0;
      @(negedge clk); pin_in = 1'b0;
      repeat (5) @(negedge clk);
      gate_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h1234;
      @(negedge clk);
      gate_tick = 1'b0; wr_en = 1'b0;
      expect_reg(2'd2, 16'h1234, "R9 write wins");

      // set beats clear
      reg_write(2'd2, 16'hFFFF);
      @(negedge clk);
      gate_tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0003;
      @(negedge clk);
      gate_tick = 1'b0; wr_en = 1'b0;
      expect_reg(2'd2, 16'h0000, "R4 gated wrap");
      expect_reg(2'd1, 16'h0002, "R10 set wins");

      finish_up();
   end
endmodule